// File: doc/BRIEF.md
# Static Memory Bus Controller with Six Chip-Select Regions

This block connects a single internal request port to an asynchronous external bus for static RAM, NOR flash and memory-mapped peripherals such as display drivers. A request carries a 26-bit byte address, two byte enables, write data and a read/write flag, and it is accepted with a valid/ready handshake. The top three address bits choose one of six regions. Each region has its own active-low chip enable and its own settings: wait count, data width of 8 or 16 bits, and strobe style. The settings arrive as static configuration vectors.

The block does one bus access at a time. Each bus cycle has three parts: a one-clock setup phase with the chip enable and address already driven, a strobe phase, and a one-clock hold phase. The strobe phase lasts for the programmed wait count plus one clock. After the count has run out, a synchronised external wait input can stretch it further. A halfword request to an 8-bit region becomes two byte cycles. When the access ends, a one-clock response returns the read data.

Top module: `smc_bus_ctrl`

## Requirements
- R1: Address bits [25:23] equal to k (0 to 5) select region k. `mem_ce_n[k]` is low from setup through hold, and at most one chip enable is low at any time.
- R2: A request whose address bits [25:23] are 6 or 7, or whose byte enables are 00, drives no chip enable or strobe. It gives `rsp_valid` on the next clock with `rsp_rdata` = 0.
- R3: Chip enable and address are driven one clock before the read or write strobe goes low. They stay driven for one clock after it rises.
- R4: With `mem_wait_n` high, the strobe stays low for exactly W+1 clocks, where W (0 to 15) is the region's 4-bit field `cfg_wait[4k+3:4k]`.
- R5: `mem_wait_n` passes through two synchronising flops and is only looked at after the W count has run out. While the synchronised value is low, the strobe stays low. A low level that is gone before the count runs out has no effect.
- R6: In a 16-bit region with `cfg_bstrobe[k]`=0, `mem_a0_bsl` is 0. On a write, `mem_wrl_n` is low during the strobe if enable bit 0 is set, and `mem_wrh_bsh_n` is low if enable bit 1 is set. A read uses `mem_rd_n`.
- R7: In a 16-bit region with `cfg_bstrobe[k]`=1, `mem_a0_bsl` = NOT enable bit 0 and `mem_wrh_bsh_n` = NOT enable bit 1, both from setup through hold. `mem_wrl_n` is then the write strobe for every write.
- R8: In an 8-bit region (`cfg_wide[k]`=0), each enabled byte gets its own bus cycle, with byte 0 before byte 1. `mem_a0_bsl` carries the byte offset, and the data travels on bus bits 7:0. The `cfg_bstrobe` setting has no effect there.
- R9: Byte order is little endian: the even byte sits on bits 7:0 and the odd byte on bits 15:8. Read data comes back in the enabled byte lanes, and lanes that were not enabled return 0.
- R10: `mem_dq_oe` is high from setup through hold of write accesses only. When it is high, `mem_dq_o` holds the write data; in an 8-bit region the selected byte is on bits 7:0 and bits 15:8 are 0. At all other times the data bus is released.
- R11: Read data is captured on the last strobe clock. `rsp_valid` is high for the one clock after the final hold, and `req_ready` is high only while no access is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wait | input | 24 | Wait count per region, 4 bits each, region k at [4k+3:4k] |
| cfg_wide | input | 6 | Per region: 1 = 16-bit device, 0 = 8-bit device |
| cfg_bstrobe | input | 6 | Per region: 1 = byte-strobe style, 0 = A0 style |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 26 | Byte address; bit 0 is ignored |
| req_be | input | 2 | Byte enables, bit 0 = even byte |
| req_wdata | input | 16 | Write data, little endian |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Read data, valid with rsp_valid |
| mem_ce_n | output | 6 | Active-low chip enables |
| mem_addr | output | 25 | External address bits 25:1 |
| mem_a0_bsl | output | 1 | Address bit 0, or active-low low-byte strobe |
| mem_rd_n | output | 1 | Active-low read strobe |
| mem_wrl_n | output | 1 | Active-low low-byte or common write strobe |
| mem_wrh_bsh_n | output | 1 | Active-low high-byte write strobe, or high-byte strobe |
| mem_dq_o | output | 16 | Data bus out |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_i | input | 16 | Data bus in |
| mem_wait_n | input | 1 | Active-low external wait request |

## Verification
The end of the wait countdown and the rise of the synchronised wait input can land in the same clock. If the design gives one of them priority, or compares against the wrong flop stage, the strobe comes out one clock too long or too short. The bench holds `mem_wait_n` low before a request and releases it after a chosen edge. One release point makes the synchronised rise land exactly on the expiry clock; a later one makes the access stretch. A cycle-by-cycle model predicts the strobe end as the later of W+2 and release+3 clocks after acceptance, and every strobe pin is compared against it on every clock.

// File: rtl/smc_pkg.sv
package smc_pkg;
    localparam int BUS_W  = 16;
    localparam int BYTE_W = 8;
    localparam int WAIT_W = 4;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_e;
endpackage

// File: rtl/smc_region_dec.sv
module smc_region_dec
    import smc_pkg::*;
#(
    parameter int ADDR_W = 26,
    parameter int NUM_CS = 6,
    parameter int SEL_W  = $clog2(NUM_CS)
) (
    input  logic [ADDR_W-1:0]        addr,
    input  logic [NUM_CS*WAIT_W-1:0] cfg_wait,
    input  logic [NUM_CS-1:0]        cfg_wide,
    input  logic [NUM_CS-1:0]        cfg_bstrobe,
    output logic                     hit,
    output logic [SEL_W-1:0]         idx,
    output logic [WAIT_W-1:0]        wait_cnt,
    output logic                     wide,
    output logic                     bstrobe
);
    logic [SEL_W-1:0]  sel;
    logic [NUM_CS-1:0] match;

    assign sel = addr[ADDR_W-1 -: SEL_W];

    for (genvar g = 0; g < NUM_CS; g++) begin : g_match
        assign match[g] = (sel == SEL_W'(g));
    end

    always_comb begin
        hit      = |match;
        idx      = '0;
        wait_cnt = '0;
        wide     = 1'b0;
        bstrobe  = 1'b0;
        for (int k = 0; k < NUM_CS; k++) begin
            if (match[k]) begin
                idx      = SEL_W'(k);
                wait_cnt = cfg_wait[k*WAIT_W +: WAIT_W];
                wide     = cfg_wide[k];
                bstrobe  = cfg_bstrobe[k];
            end
        end
    end
endmodule

// File: rtl/smc_wait_sync.sv
module smc_wait_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic wait_n_raw,
    output logic wait_ok
);
    typedef struct packed {
        logic s1;
        logic s2;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d.s1 = wait_n_raw;
        sy_d.s2 = sy_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '{s1: 1'b1, s2: 1'b1};
        else        sy_q <= sy_d;
    end

    assign wait_ok = sy_q.s2;
endmodule

// File: rtl/smc_bus_ctrl.sv
module smc_bus_ctrl
    import smc_pkg::*;
#(
    parameter int ADDR_W = 26,
    parameter int NUM_CS = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CS*WAIT_W-1:0] cfg_wait,
    input  logic [NUM_CS-1:0]        cfg_wide,
    input  logic [NUM_CS-1:0]        cfg_bstrobe,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_write,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [1:0]               req_be,
    input  logic [BUS_W-1:0]         req_wdata,
    output logic                     rsp_valid,
    output logic [BUS_W-1:0]         rsp_rdata,
    output logic [NUM_CS-1:0]        mem_ce_n,
    output logic [ADDR_W-1:1]        mem_addr,
    output logic                     mem_a0_bsl,
    output logic                     mem_rd_n,
    output logic                     mem_wrl_n,
    output logic                     mem_wrh_bsh_n,
    output logic [BUS_W-1:0]         mem_dq_o,
    output logic                     mem_dq_oe,
    input  logic [BUS_W-1:0]         mem_dq_i,
    input  logic                     mem_wait_n
);
    localparam int SEL_W = $clog2(NUM_CS);

    typedef struct packed {
        phase_e              ph;
        logic [SEL_W-1:0]    rgn;
        logic                wr;
        logic [ADDR_W-1:1]   adr;
        logic [1:0]          be;
        logic [BUS_W-1:0]    wdat;
        logic                wide;
        logic                bsm;
        logic [WAIT_W-1:0]   wt;
        logic                lane;
        logic                more;
        logic [WAIT_W-1:0]   cnt;
        logic [BUS_W-1:0]    rdat;
        logic                rsp;
        logic [NUM_CS-1:0]   ce_n;
        logic                a0;
        logic                rd_n;
        logic                wrl_n;
        logic                wrh_n;
        logic                oe;
        logic [BUS_W-1:0]    dq;
    } ctl_t;

    ctl_t cq, cd;

    logic              dec_hit, dec_wide, dec_bs, wait_ok;
    logic [SEL_W-1:0]  dec_idx;
    logic [WAIT_W-1:0] dec_wait;
    logic              act, stb;

    smc_region_dec #(.ADDR_W(ADDR_W), .NUM_CS(NUM_CS), .SEL_W(SEL_W)) u_dec (
        .addr        (req_addr),
        .cfg_wait    (cfg_wait),
        .cfg_wide    (cfg_wide),
        .cfg_bstrobe (cfg_bstrobe),
        .hit         (dec_hit),
        .idx         (dec_idx),
        .wait_cnt    (dec_wait),
        .wide        (dec_wide),
        .bstrobe     (dec_bs)
    );

    smc_wait_sync u_wsync (
        .clk        (clk),
        .rst_n      (rst_n),
        .wait_n_raw (mem_wait_n),
        .wait_ok    (wait_ok)
    );

    always_comb begin
        cd     = cq;
        cd.rsp = 1'b0;
        case (cq.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    if (!dec_hit || req_be == 2'b00) begin
                        cd.rsp  = 1'b1;
                        cd.rdat = '0;
                    end else begin
                        cd.ph   = PH_SETUP;
                        cd.rgn  = dec_idx;
                        cd.wr   = req_write;
                        cd.adr  = req_addr[ADDR_W-1:1];
                        cd.be   = req_be;
                        cd.wdat = req_wdata;
                        cd.wide = dec_wide;
                        cd.bsm  = dec_bs & dec_wide;
                        cd.wt   = dec_wait;
                        cd.lane = !dec_wide && !req_be[0];
                        cd.more = !dec_wide && (&req_be);
                        cd.rdat = '0;
                    end
                end
            end
            PH_SETUP: begin
                cd.ph  = PH_STROBE;
                cd.cnt = cq.wt;
            end
            PH_STROBE: begin
                if (cq.cnt != '0) begin
                    cd.cnt = cq.cnt - 1'b1;
                end else if (wait_ok) begin
                    cd.ph = PH_HOLD;
                    if (!cq.wr) begin
                        if (cq.wide) begin
                            if (cq.be[0]) cd.rdat[BYTE_W-1:0]     = mem_dq_i[BYTE_W-1:0];
                            if (cq.be[1]) cd.rdat[BUS_W-1:BYTE_W] = mem_dq_i[BUS_W-1:BYTE_W];
                        end else if (cq.lane) begin
                            cd.rdat[BUS_W-1:BYTE_W] = mem_dq_i[BYTE_W-1:0];
                        end else begin
                            cd.rdat[BYTE_W-1:0]     = mem_dq_i[BYTE_W-1:0];
                        end
                    end
                end
            end
            PH_HOLD: begin
                if (cq.more) begin
                    cd.more = 1'b0;
                    cd.lane = 1'b1;
                    cd.ph   = PH_SETUP;
                end else begin
                    cd.ph  = PH_IDLE;
                    cd.rsp = 1'b1;
                end
            end
            default: cd.ph = PH_IDLE;
        endcase

        // pins are registered copies of the next phase
        act = (cd.ph != PH_IDLE);
        stb = (cd.ph == PH_STROBE);
        for (int k = 0; k < NUM_CS; k++) begin
            cd.ce_n[k] = !(act && (int'(cd.rgn) == k));
        end
        cd.a0    = cd.bsm ? !(act && cd.be[0]) : (!cd.wide && cd.lane);
        cd.rd_n  = !(stb && !cd.wr);
        cd.wrl_n = !(stb && cd.wr && (cd.bsm || !cd.wide || cd.be[0]));
        cd.wrh_n = cd.bsm ? !(act && cd.be[1])
                          : !(stb && cd.wr && cd.wide && cd.be[1]);
        cd.oe    = act && cd.wr;
        cd.dq    = cd.wide ? cd.wdat
                           : {{BYTE_W{1'b0}}, (cd.lane ? cd.wdat[BUS_W-1:BYTE_W]
                                                       : cd.wdat[BYTE_W-1:0])};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cq       <= '0;
            cq.ph    <= PH_IDLE;
            cq.ce_n  <= '1;
            cq.a0    <= 1'b1;
            cq.rd_n  <= 1'b1;
            cq.wrl_n <= 1'b1;
            cq.wrh_n <= 1'b1;
        end else begin
            cq <= cd;
        end
    end

    assign req_ready     = (cq.ph == PH_IDLE);
    assign rsp_valid     = cq.rsp;
    assign rsp_rdata     = cq.rdat;
    assign mem_ce_n      = cq.ce_n;
    assign mem_addr      = cq.adr;
    assign mem_a0_bsl    = cq.a0;
    assign mem_rd_n      = cq.rd_n;
    assign mem_wrl_n     = cq.wrl_n;
    assign mem_wrh_bsh_n = cq.wrh_n;
    assign mem_dq_o      = cq.dq;
    assign mem_dq_oe     = cq.oe;

    // R1: never two chip enables at once
    a_r1_one_ce: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mem_ce_n));

    // R2: a strobe only ever appears under a chip enable
    a_r2_strobe_under_ce: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_rd_n || !mem_wrl_n) |-> !(&mem_ce_n));

    // R3: chip enable and address settled one clock before the strobe falls
    a_r3_setup_rd: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_rd_n) |-> ($past(mem_ce_n) == mem_ce_n && $stable(mem_addr)));

    a_r3_setup_wr: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_wrl_n) |-> ($past(mem_ce_n) == mem_ce_n && $stable(mem_addr)));

    // R3: chip enable still low in the clock after the strobe rises
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_rd_n) || $rose(mem_wrl_n)) |-> !(&mem_ce_n));

    // R5: a strobe only ends once the synchronised wait has released
    a_r5_wait_release: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_rd_n) || $rose(mem_wrl_n)) |-> $past(wait_ok));

    // R10: never drive the data bus while the read strobe is low
    a_r10_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd_n |-> !mem_dq_oe);

    // R11: a response is only given while the controller is idle
    a_r11_rsp_idle: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (&mem_ce_n));
endmodule

// File: tb/test_smc_bus_ctrl.sv
module test_smc_bus_ctrl;
    localparam int AW  = 26;
    localparam int NCS = 6;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic              rst_n;
    logic [NCS*4-1:0]  cfg_wait;
    logic [NCS-1:0]    cfg_wide, cfg_bstrobe;
    logic              req_valid, req_ready, req_write;
    logic [AW-1:0]     req_addr;
    logic [1:0]        req_be;
    logic [15:0]       req_wdata;
    logic              rsp_valid;
    logic [15:0]       rsp_rdata;
    logic [NCS-1:0]    mem_ce_n;
    logic [AW-1:1]     mem_addr;
    logic              mem_a0_bsl, mem_rd_n, mem_wrl_n, mem_wrh_bsh_n;
    logic [15:0]       mem_dq_o, mem_dq_i;
    logic              mem_dq_oe, mem_wait_n;

    smc_bus_ctrl #(.ADDR_W(AW), .NUM_CS(NCS)) i_smc_bus_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cfg_wait(cfg_wait), .cfg_wide(cfg_wide), .cfg_bstrobe(cfg_bstrobe),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .mem_ce_n(mem_ce_n), .mem_addr(mem_addr), .mem_a0_bsl(mem_a0_bsl),
        .mem_rd_n(mem_rd_n), .mem_wrl_n(mem_wrl_n), .mem_wrh_bsh_n(mem_wrh_bsh_n),
        .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i),
        .mem_wait_n(mem_wait_n)
    );

    int n_cmp = 0;
    int n_bad = 0;

    function automatic logic [7:0] fmem(input logic [AW-1:0] a);
        return (a[7:0] * 8'd37 + 8'd11) ^ a[15:8];
    endfunction

    // external memory model: content is a function of the byte address
    always_comb begin
        logic wide_now;
        wide_now = 1'b1;
        for (int k = 0; k < NCS; k++) if (!mem_ce_n[k]) wide_now = cfg_wide[k];
        if (wide_now) mem_dq_i = {fmem({mem_addr, 1'b1}), fmem({mem_addr, 1'b0})};
        else          mem_dq_i = {8'hEE, fmem({mem_addr, mem_a0_bsl})};
    end

    typedef struct packed {
        logic          acc;
        logic [NCS-1:0] ce_n;
        logic [AW-1:1] adr;
        logic          a0, rd_n, wrl_n, wrh_n, oe, rdy, rspv;
        logic [15:0]   dq, rdat;
    } exp_t;

    exp_t  q[$];
    string tq[$];

    function automatic exp_t idle_e();
        exp_t e;
        e = '0;
        e.ce_n = '1; e.rd_n = 1'b1; e.wrl_n = 1'b1; e.wrh_n = 1'b1; e.rdy = 1'b1;
        return e;
    endfunction

    function automatic void put(exp_t e, string t);
        q.push_back(e);
        tq.push_back(t);
    endfunction

    // builds the whole expected pin sequence of one request
    function automatic void push_req(string tag, bit wr, logic [AW-1:0] a,
                                     logic [1:0] be, logic [15:0] wd, int rel);
        int sel, w, s_len, lane;
        bit wide, bs;
        int lanes[$];
        logic [15:0] rd;
        exp_t e, s, r;
        sel = int'(a[AW-1:AW-3]);
        r = idle_e();
        r.rspv = 1'b1;
        if (sel >= NCS || be == 2'b00) begin
            r.rdat = 16'h0;
            put(r, tag);
            return;
        end
        w    = int'(cfg_wait[sel*4 +: 4]);
        wide = cfg_wide[sel];
        bs   = cfg_bstrobe[sel] && wide;
        rd   = 16'h0;
        if (wide) lanes.push_back(0);
        else begin
            if (be[0]) lanes.push_back(0);
            if (be[1]) lanes.push_back(1);
        end
        foreach (lanes[i]) begin
            lane  = lanes[i];
            s_len = w + 1;
            if (rel > 0 && i == 0) s_len = ((w + 2 > rel + 3) ? w + 2 : rel + 3) - 1;
            e = '0;
            e.acc   = 1'b1;
            e.ce_n  = ~(NCS'(1) << sel);
            e.adr   = a[AW-1:1];
            e.a0    = bs ? ~be[0] : (wide ? 1'b0 : lane[0]);
            e.rd_n  = 1'b1;
            e.wrl_n = 1'b1;
            e.wrh_n = bs ? ~be[1] : 1'b1;
            e.oe    = wr;
            e.dq    = wide ? wd : {8'h00, (lane == 1) ? wd[15:8] : wd[7:0]};
            put(e, tag);
            s = e;
            s.rd_n  = wr;
            s.wrl_n = !(wr && (bs || !wide || be[0]));
            if (!bs) s.wrh_n = !(wr && wide && be[1]);
            for (int k = 0; k < s_len; k++) put(s, tag);
            put(e, tag);
            if (!wr) begin
                if (wide) begin
                    if (be[0]) rd[7:0]  = fmem({a[AW-1:1], 1'b0});
                    if (be[1]) rd[15:8] = fmem({a[AW-1:1], 1'b1});
                end else if (lane == 1) rd[15:8] = fmem({a[AW-1:1], 1'b1});
                else                    rd[7:0]  = fmem({a[AW-1:1], 1'b0});
            end
        end
        r.rdat = rd;
        put(r, tag);
    endfunction

    task automatic chk(string tag, string f, logic [31:0] g, logic [31:0] x);
        n_cmp++;
        if (g !== x) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h at %0t", tag, f, g, x, $time);
        end
    endtask

    // per-clock comparison against the reference sequence
    always @(negedge clk) begin
        exp_t  e;
        string t;
        if (rst_n) begin
            if (q.size() != 0) begin
                e = q.pop_front();
                t = tq.pop_front();
            end else begin
                e = idle_e();
                t = "R10";
            end
            chk(t, "ce_n",    32'(mem_ce_n),      32'(e.ce_n));
            chk(t, "rd_n",    32'(mem_rd_n),      32'(e.rd_n));
            chk(t, "wrl_n",   32'(mem_wrl_n),     32'(e.wrl_n));
            chk(t, "wrh_bsh", 32'(mem_wrh_bsh_n), 32'(e.wrh_n));
            chk(t, "dq_oe",   32'(mem_dq_oe),     32'(e.oe));
            chk(t, "ready",   32'(req_ready),     32'(e.rdy));
            chk(t, "rsp",     32'(rsp_valid),     32'(e.rspv));
            if (e.acc) begin
                chk(t, "addr", 32'(mem_addr),   32'(e.adr));
                chk(t, "a0",   32'(mem_a0_bsl), 32'(e.a0));
            end
            if (e.oe)   chk(t, "dq_o",  32'(mem_dq_o),  32'(e.dq));
            if (e.rspv) chk(t, "rdata", 32'(rsp_rdata), 32'(e.rdat));
        end
    end

    task automatic do_req(string tag, bit wr, logic [AW-1:0] a, logic [1:0] be,
                          logic [15:0] wd, int rel);
        if (rel > 0) begin
            mem_wait_n = 1'b0;
            repeat (4) @(negedge clk);
        end
        @(negedge clk); #1;
        push_req(tag, wr, a, be, wd, rel);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = wd;
        @(posedge clk); #1;
        req_valid = 1'b0;
        if (rel > 0) begin
            repeat (rel) @(posedge clk);
            #1 mem_wait_n = 1'b1;
        end
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    bit done = 1'b0;

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // region: wait, width, strobe style
        cfg_wait    = {4'd0, 4'd2, 4'd1, 4'd15, 4'd3, 4'd0};
        cfg_wide    = 6'b010011;
        cfg_bstrobe = 6'b001010;
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
        req_be = 2'b00; req_wdata = '0; mem_wait_n = 1'b1;
        repeat (5) @(negedge clk);
        #1 rst_n = 1'b1;
        repeat (3) @(negedge clk);                                  // R10 reset idle state

        do_req("R6",  1'b1, 26'h0000124, 2'b11, 16'hA55A, 0);       // region0 A0 write
        do_req("R9",  1'b0, 26'h0000124, 2'b11, 16'h0,    0);       // R6 read both lanes
        do_req("R6",  1'b1, 26'h0000126, 2'b10, 16'h1234, 0);       // high lane only
        do_req("R7",  1'b1, 26'h0800032, 2'b01, 16'hBEEF, 0);       // byte-strobe write
        do_req("R7",  1'b0, 26'h0800032, 2'b10, 16'h0,    0);       // R9 high lane read
        do_req("R3",  1'b0, 26'h0800040, 2'b11, 16'h0,    0);       // R3 setup/hold
        do_req("R8",  1'b1, 26'h1000456, 2'b11, 16'hC3D2, 0);       // R4 wait 15, split
        do_req("R8",  1'b0, 26'h1000456, 2'b11, 16'h0,    0);       // split read
        do_req("R8",  1'b0, 26'h1800078, 2'b10, 16'h0,    0);       // style ignored
        do_req("R1",  1'b1, 26'h2800010, 2'b01, 16'h00F1, 0);       // region5
        do_req("R4",  1'b0, 26'h2000222, 2'b01, 16'h0,    0);       // region4 wait 2
        do_req("R5",  1'b0, 26'h2000222, 2'b11, 16'h0,    8);       // stretched
        do_req("R5",  1'b0, 26'h2000224, 2'b11, 16'h0,    1);       // released at expiry
        do_req("R5",  1'b1, 26'h2000226, 2'b10, 16'h7788, 4);       // stretched write
        do_req("R2",  1'b0, 26'h3000010, 2'b11, 16'h0,    0);       // unmapped 6
        do_req("R2",  1'b1, 26'h3800010, 2'b11, 16'h1111, 0);       // unmapped 7
        do_req("R2",  1'b0, 26'h0000010, 2'b00, 16'h0,    0);       // no byte enabled
        do_req("R11", 1'b0, 26'h0000200, 2'b01, 16'h0,    0);       // response timing
        do_req("R10", 1'b0, 26'h1000301, 2'b01, 16'h0,    0);       // no drive on read

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule